// File: doc/BRIEF.md
# Pulse-Age Coincidence Trigger

This block makes the second-level trigger decision for a group of detector channels. Each channel raises a one-cycle hit strobe when its first-level discriminator fires. The block then tracks how old that pulse is, counted in sample ticks. A set of programmable trigger conditions is checked against those ages in every cycle. Each condition names the channels that must be hit, the channels that veto it, and the channels to read out when it fires.

Four shared age thresholds define two windows. The wide window runs from the lowest threshold to the highest, and the narrow window lies inside it. A required channel counts only when its pulse age is inside the narrow window. A veto channel blocks a condition when its pulse age is anywhere inside the wide window. When a pulse reaches the highest threshold, the channel's age is cleared and a reset pulse goes to the channel's peak detector.

A trigger fires at most once per event. It reports every condition met in the firing cycle and the union of their readout masks. It then stays quiet until every channel has gone idle again. A random-trigger request fires a readout of all channels.

Top module: `coinc_trigger`

## Requirements
- R1: With thresholds w1 ≤ w2 ≤ w3 ≤ w4 (w1 ≥ 2), a channel is in the wide window when w1 ≤ age ≤ w4 and in the narrow window when w2 ≤ age ≤ w3, both bounds inclusive; an idle channel (age 0) is in neither.
- R2: Condition t is met in a cycle only when its required mask is non-zero and every channel in that mask is in the narrow window.
- R3: Condition t is not met while any channel in its veto mask is in the wide window.
- R4: A channel whose age is non-zero and at least w4 returns to age 0 at the next clock edge, and peakReset for that channel is high for exactly that one following cycle; a hit strobe arriving in the expiring cycle is dropped.
- R5: An idle channel goes to age 1 on its hit strobe. A busy channel advances by one on each sampleTick and otherwise holds its age. A further hit on a busy channel does not restart its age.
- R6: Condition t uses bits [t*NCH +: NCH] of each flat mask input, with bit c meaning channel c. On a firing, trigBits bit t is set for every condition met in the evaluated cycle, and readoutMask is the OR of the readout masks of those conditions.
- R7: When randomReq is high in a cycle where firing is allowed, the trigger fires, trigBits reports the conditions met in that cycle, and readoutMask is all ones.
- R8: trigFire is a one-cycle strobe that appears one cycle after the evaluated cycle, with trigBits and readoutMask updated at the same edge and held until the next firing. After a firing, no further firing happens until a cycle in which every channel's age is 0 has passed.
- R9: Thresholds and masks are captured into the block only during reset and in cycles where every channel is idle; changing them while any pulse is active has no effect on that event.
- R10: A synchronous reset clears all ages, trigFire, trigBits, readoutMask, peakReset and the event lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | Advances every busy channel's age by one |
| hitIn | input | NCH | Per-channel first-level hit strobes |
| randomReq | input | 1 | Random trigger request, reads out all channels |
| winWideLo | input | AW | Threshold w1, lower edge of the wide window |
| winNarrowLo | input | AW | Threshold w2, lower edge of the narrow window |
| winNarrowHi | input | AW | Threshold w3, upper edge of the narrow window |
| winWideHi | input | AW | Threshold w4, upper edge of the wide window and expiry age |
| reqMaskFlat | input | NT*NCH | Required-channel masks, one NCH slice per condition |
| vetoMaskFlat | input | NT*NCH | Veto masks, one NCH slice per condition |
| readMaskFlat | input | NT*NCH | Readout masks, one NCH slice per condition |
| trigFire | output | 1 | One-cycle trigger strobe |
| trigBits | output | NT | Conditions met at the last firing |
| readoutMask | output | NCH | Channels to read out for the last firing |
| peakReset | output | NCH | Per-channel peak-detector reset pulse |

## Verification
The bench drives the window edges one age below, at and one age above each threshold. A design with an exclusive bound would fire one tick late or not at all. It also drives a veto pulse that sits outside the narrow window but inside the wide one, where a design that vetoed only on the narrow window would let a false trigger through. Staggered hits that satisfy a sparse condition before a wider one test whether the design refires inside one event. Threshold and mask changes made mid-event test whether the design reads its configuration live. Pulses that expire in the same cycle as a new hit, and stretches with no sample tick, test whether ages restart or drift.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef struct packed {
    logic cfgLoad;
    logic capture;
    logic forceAll;
  } ctrlStrobe_t;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HELD  = 1'b1
  } lockState_t;
endpackage

// File: rtl/coinc_chan_age.sv
module coinc_chan_age #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hit,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] age,
  output logic          peakRst
);
  logic expire;
  assign expire = (age != '0) && (age >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      peakRst <= 1'b0;
    end else begin
      peakRst <= expire;
      if (expire) begin
        age <= '0;
      end else if (age == '0) begin
        if (hit) age <= AW'(1);
      end else if (tick) begin
        age <= age + AW'(1);
      end
    end
  end

  // R4: expiry clears the age and pulses the peak reset
  a_r4_expire_clears: assert property (@(posedge clk) disable iff (rst)
    expire |=> (age == '0) && peakRst);

  // R5: fresh hit on an idle channel starts at one
  a_r5_start_at_one: assert property (@(posedge clk) disable iff (rst)
    (age == '0) && hit |=> (age == AW'(1)));

  // R5: no tick, no movement
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (age != '0) && !expire && !tick |=> $stable(age));
endmodule

// File: rtl/coinc_datapath.sv
module coinc_datapath
  import coinc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NT  = 4,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NCH-1:0]    hit,
  input  logic [AW-1:0]     thrW1,
  input  logic [AW-1:0]     thrW2,
  input  logic [AW-1:0]     thrW3,
  input  logic [AW-1:0]     thrW4,
  input  logic [NT*NCH-1:0] reqIn,
  input  logic [NT*NCH-1:0] vetoIn,
  input  logic [NT*NCH-1:0] readIn,
  input  ctrlStrobe_t       ctrl,
  output logic [NT-1:0]     condMet,
  output logic              allIdle,
  output logic [NT-1:0]     trigBits,
  output logic [NCH-1:0]    readoutMask,
  output logic [NCH-1:0]    peakReset
);
  localparam int MW = NT * NCH;

  logic [AW-1:0] cfgW1, cfgW2, cfgW3, cfgW4;
  logic [MW-1:0] cfgReq, cfgVeto, cfgRead;

  always_ff @(posedge clk) begin
    if (rst || ctrl.cfgLoad) begin
      cfgW1   <= thrW1;
      cfgW2   <= thrW2;
      cfgW3   <= thrW3;
      cfgW4   <= thrW4;
      cfgReq  <= reqIn;
      cfgVeto <= vetoIn;
      cfgRead <= readIn;
    end
  end

  logic [AW-1:0]  ageQ [NCH];
  logic [NCH-1:0] busy, inNarrow, inWide;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    coinc_chan_age #(.AW(AW)) u_age (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .hit    (hit[c]),
      .limit  (cfgW4),
      .age    (ageQ[c]),
      .peakRst(peakReset[c])
    );
    assign busy[c]     = (ageQ[c] != '0);
    assign inNarrow[c] = busy[c] && (ageQ[c] >= cfgW2) && (ageQ[c] <= cfgW3);
    assign inWide[c]   = busy[c] && (ageQ[c] >= cfgW1) && (ageQ[c] <= cfgW4);
  end

  assign allIdle = ~|busy;

  for (genvar t = 0; t < NT; t++) begin : g_cond
    logic [NCH-1:0] reqT, vetoT;
    assign reqT  = cfgReq[t*NCH +: NCH];
    assign vetoT = cfgVeto[t*NCH +: NCH];
    assign condMet[t] = (reqT != '0) && ((reqT & ~inNarrow) == '0)
                        && ((vetoT & inWide) == '0);
  end

  logic [NCH-1:0] mergedMask;
  always_comb begin
    mergedMask = '0;
    for (int t = 0; t < NT; t++) begin
      if (condMet[t]) mergedMask = mergedMask | cfgRead[t*NCH +: NCH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigBits    <= '0;
      readoutMask <= '0;
    end else if (ctrl.capture) begin
      trigBits    <= condMet;
      readoutMask <= ctrl.forceAll ? '1 : mergedMask;
    end
  end

  // R9: configuration frozen while any pulse is active
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !allIdle |=> $stable({cfgW1, cfgW2, cfgW3, cfgW4, cfgReq, cfgVeto, cfgRead}));

  // R7: random capture reads every channel
  a_r7_read_all: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture && ctrl.forceAll |=> (&readoutMask));

  // R6: held outputs change only on capture
  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(trigBits) && $stable(readoutMask));
endmodule

// File: rtl/coinc_control.sv
module coinc_control
  import coinc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        anyCond,
  input  logic        randomReq,
  input  logic        allIdle,
  output ctrlStrobe_t ctrl,
  output logic        trigFire
);
  lockState_t state;
  logic fire;

  assign fire          = (state == ST_ARMED) && (anyCond || randomReq);
  assign ctrl.cfgLoad  = allIdle;
  assign ctrl.capture  = fire;
  assign ctrl.forceAll = randomReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ARMED;
      trigFire <= 1'b0;
    end else begin
      trigFire <= fire;
      unique case (state)
        ST_ARMED: if (fire)    state <= ST_HELD;
        ST_HELD:  if (allIdle) state <= ST_ARMED;
        default:  state <= ST_ARMED;
      endcase
    end
  end

  // R8: a firing is never followed directly by another
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    trigFire |=> !trigFire);

  // R8: held lock blocks firing until all channels are idle
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HELD) && !allIdle |=> !trigFire && (state == ST_HELD));
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NT  = 4,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic [NCH-1:0]    hitIn,
  input  logic              randomReq,
  input  logic [AW-1:0]     winWideLo,
  input  logic [AW-1:0]     winNarrowLo,
  input  logic [AW-1:0]     winNarrowHi,
  input  logic [AW-1:0]     winWideHi,
  input  logic [NT*NCH-1:0] reqMaskFlat,
  input  logic [NT*NCH-1:0] vetoMaskFlat,
  input  logic [NT*NCH-1:0] readMaskFlat,
  output logic              trigFire,
  output logic [NT-1:0]     trigBits,
  output logic [NCH-1:0]    readoutMask,
  output logic [NCH-1:0]    peakReset
);
  ctrlStrobe_t   ctrl;
  logic [NT-1:0] condMet;
  logic          allIdle;

  coinc_datapath #(.NCH(NCH), .NT(NT), .AW(AW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .tick       (sampleTick),
    .hit        (hitIn),
    .thrW1      (winWideLo),
    .thrW2      (winNarrowLo),
    .thrW3      (winNarrowHi),
    .thrW4      (winWideHi),
    .reqIn      (reqMaskFlat),
    .vetoIn     (vetoMaskFlat),
    .readIn     (readMaskFlat),
    .ctrl       (ctrl),
    .condMet    (condMet),
    .allIdle    (allIdle),
    .trigBits   (trigBits),
    .readoutMask(readoutMask),
    .peakReset  (peakReset)
  );

  coinc_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .anyCond  (|condMet),
    .randomReq(randomReq),
    .allIdle  (allIdle),
    .ctrl     (ctrl),
    .trigFire (trigFire)
  );
endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;
  localparam int NCH = 8;
  localparam int NT  = 4;
  localparam int AW  = 6;
  localparam int MW  = NT * NCH;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, rnd = 1'b0;
  logic [NCH-1:0] hit = '0;
  logic [AW-1:0] w1 = 2, w2 = 3, w3 = 5, w4 = 8;
  logic [MW-1:0] reqF = '0, vetoF = '0, readF = '0;
  logic trigFire;
  logic [NT-1:0] trigBits;
  logic [NCH-1:0] readoutMask, peakReset;

  coinc_trigger #(.NCH(NCH), .NT(NT), .AW(AW)) uut (
    .clk(clk), .rst(rst), .sampleTick(tick), .hitIn(hit), .randomReq(rnd),
    .winWideLo(w1), .winNarrowLo(w2), .winNarrowHi(w3), .winWideHi(w4),
    .reqMaskFlat(reqF), .vetoMaskFlat(vetoF), .readMaskFlat(readF),
    .trigFire(trigFire), .trigBits(trigBits), .readoutMask(readoutMask),
    .peakReset(peakReset)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference state built from the requirements
  int unsigned mAge [NCH];
  int unsigned mW1, mW2, mW3, mW4;
  logic [MW-1:0] mReq, mVeto, mRead;
  bit mLocked;
  logic mFire;
  logic [NT-1:0] mBits;
  logic [NCH-1:0] mMask, mPeak;

  task automatic loadCfg();
    mW1 = w1; mW2 = w2; mW3 = w3; mW4 = w4;
    mReq = reqF; mVeto = vetoF; mRead = readF;
  endtask

  task automatic modelStep();
    logic [NCH-1:0] inN, inW, orM;
    logic [NT-1:0] cond;
    bit idle, fire;
    if (rst) begin
      for (int c = 0; c < NCH; c++) mAge[c] = 0;
      mLocked = 0; mFire = 0; mBits = '0; mMask = '0; mPeak = '0;
      loadCfg();
      return;
    end
    idle = 1;
    for (int c = 0; c < NCH; c++) begin
      if (mAge[c] != 0) idle = 0;
      inN[c] = (mAge[c] != 0) && (mAge[c] >= mW2) && (mAge[c] <= mW3);
      inW[c] = (mAge[c] != 0) && (mAge[c] >= mW1) && (mAge[c] <= mW4);
    end
    orM = '0;
    for (int t = 0; t < NT; t++) begin
      logic [NCH-1:0] rq, vt;
      rq = mReq[t*NCH +: NCH];
      vt = mVeto[t*NCH +: NCH];
      cond[t] = (rq != 0) && ((rq & ~inN) == 0) && ((vt & inW) == 0);
      if (cond[t]) orM |= mRead[t*NCH +: NCH];
    end
    fire = !mLocked && ((cond != 0) || rnd);
    mFire = fire;
    if (fire) begin
      mBits = cond;
      mMask = rnd ? '1 : orM;
    end
    if (fire) mLocked = 1;
    else if (mLocked && idle) mLocked = 0;
    for (int c = 0; c < NCH; c++) begin
      mPeak[c] = 0;
      if (mAge[c] != 0 && mAge[c] >= mW4) begin
        mAge[c] = 0; mPeak[c] = 1;
      end else if (mAge[c] == 0) begin
        if (hit[c]) mAge[c] = 1;
      end else if (tick) mAge[c] = mAge[c] + 1;
    end
    if (idle) loadCfg();
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "trigFire", 32'(trigFire), 32'(mFire));
    chk(tag, "trigBits", 32'(trigBits), 32'(mBits));
    chk(tag, "readoutMask", 32'(readoutMask), 32'(mMask));
    chk(tag, "peakReset", 32'(peakReset), 32'(mPeak));
    hit = '0; rnd = 1'b0;
  endtask

  task automatic idleRun(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  int fireCount;

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    rst = 1; hit = '1; tick = 1;
    cyc("R10"); cyc("R10");
    rst = 0;
    chk("R10", "trigFire after reset", 32'(trigFire), 32'd0);

    // R1/R2: condition 0 needs ch0 and ch1; window edges 3..5
    w1 = 2; w2 = 3; w3 = 5; w4 = 8;
    reqF = '0; reqF[1:0] = 2'b11; readF = '0; readF[7:0] = 8'h0F; vetoF = '0;
    tick = 1; cyc("R1");
    hit = 8'h01; cyc("R1");
    cyc("R1");
    hit = 8'h02; cyc("R5");        // ch1 two ages behind
    fireCount = 0;
    for (int i = 0; i < 12; i++) begin cyc("R1"); if (trigFire) fireCount++; end
    chk("R8", "fires in one event", 32'(fireCount), 32'd1);
    idleRun("R4", 4);

    // R3: veto channel 2 at age w1 (inside wide, outside narrow)
    w1 = 2; w2 = 4; w3 = 6; w4 = 9;
    vetoF = '0; vetoF[2] = 1'b1;
    cyc("R3");
    hit = 8'h03; cyc("R3");
    cyc("R3");
    hit = 8'h04; cyc("R3");
    idleRun("R3", 14);

    // R5: ages hold without tick, re-hit ignored
    tick = 0; hit = 8'h03; cyc("R5");
    for (int i = 0; i < 5; i++) begin hit = 8'h03; cyc("R5"); end
    tick = 1; idleRun("R5", 14);

    // R6: two conditions satisfied together, masks merged
    vetoF = '0;
    reqF = '0; reqF[0] = 1'b1; reqF[NCH + 1] = 1'b1; reqF[2*NCH + 5] = 1'b1;
    readF = '0; readF[7:0] = 8'h11; readF[NCH +: 8] = 8'h22; readF[2*NCH +: 8] = 8'h44;
    cyc("R6");
    hit = 8'h03; cyc("R6");
    idleRun("R6", 14);

    // R7: random request, also while locked
    rnd = 1; cyc("R7");
    rnd = 1; cyc("R7");
    hit = 8'h01; rnd = 1; cyc("R7");
    rnd = 1; cyc("R7");
    idleRun("R7", 14);

    // R9: change config during an active pulse
    hit = 8'h03; cyc("R9");
    w2 = 1; w3 = 40; w4 = 60; reqF = '1; readF = '1;
    idleRun("R9", 14);
    w1 = 2; w2 = 3; w3 = 5; w4 = 8;
    idleRun("R9", 3);

    // R4: expiry coinciding with a new hit on the same channel
    hit = 8'h80; cyc("R4");
    for (int i = 0; i < 7; i++) cyc("R4");
    hit = 8'h80; cyc("R4");
    idleRun("R4", 12);

    // R2: random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 400 == 0) begin
        int unsigned v [4];
        for (int k = 0; k < 4; k++) v[k] = 2 + $urandom % 30;
        v.sort();
        w1 = AW'(v[0]); w2 = AW'(v[1]); w3 = AW'(v[2]); w4 = AW'(v[3]);
        reqF = MW'($urandom & $urandom);
        vetoF = MW'($urandom & $urandom & $urandom);
        readF = MW'($urandom);
      end
      if ($urandom % 97 == 0) reqF = MW'($urandom & $urandom);
      tick = ($urandom % 4) != 0;
      for (int c = 0; c < NCH; c++) hit[c] = ($urandom % 12) == 0;
      rnd = ($urandom % 80) == 0;
      cyc("R2");
    end

    rst = 1; hit = '1; cyc("R10");
    rst = 0; cyc("R10");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule